// File: doc/BRIEF.md
# Power-Management Event and SCI Generator

This block collects power-management events and drives a level-sensitive system control interrupt (SCI). It holds an event status register, an event enable register and a free-running power-management timer. Three hardware event inputs set status bits: the power button, the real-time clock alarm and the global lock. The timer sets a status bit of its own each time its most significant bit changes value. Software clears a status bit by writing a one to it.

The registers sit in a 64-byte I/O window. A configuration base input sets the window's address, and bit 0 of a configuration control byte turns the window on. The SCI is high while at least one of four qualifying sources has both its status bit and its enable bit set. Any other enable or status position has no effect on the SCI.

Top module: `pm_event_sci`

## Requirements
- R1: After reset the status register, the enable register and the timer are all zero, and `sci` is low.
- R2: `io_hit` is high exactly when `cfg_ctrl[0]` is 1 and `io_addr[15:6]` equals `cfg_base[15:6]`. Bits [5:0] and [31:16] of `cfg_base` are ignored, and the window offset is `io_addr[5:0]`.
- R3: While `io_hit` is low, `io_rdata` is zero and `io_wr` changes no register.
- R4: A high `pwrbtn_evt`, `rtc_evt` or `glock_evt` sets status bit 8, 10 or 5 respectively at the next clock edge. An event wins over a same-cycle clear of its bit.
- R5: A write at offset 0 clears each status bit whose `io_wdata` bit is 1 and leaves the bits written with 0 unchanged. The status register reads at offset 0, and status bits other than 0, 5, 8 and 10 read as zero.
- R6: The 16-bit enable register is written and read back at offset 2.
- R7: The timer (TMR_W bits, 24 by default) advances by one on each clock edge where `tmr_tick` is high and wraps to zero. It reads zero-extended at offset 8, and writes to offset 8 are ignored.
- R8: Status bit 0 is set when a tick changes the timer's MSB, but only while enable bit 0 is set.
- R9: `sci` is high exactly when some bit among 0, 5, 8 and 10 is set in both status and enable. Enable bits at other positions do not raise `sci`.
- R10: Window offsets other than 0, 2 and 8 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_tick | input | 1 | Timer advance enable |
| pwrbtn_evt | input | 1 | Power button event |
| rtc_evt | input | 1 | RTC alarm event |
| glock_evt | input | 1 | Global lock event |
| cfg_base | input | 32 | Window base address; only bits [15:6] are used |
| cfg_ctrl | input | 8 | Control byte; bit 0 enables the window |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Read data, combinational from the address |
| io_hit | output | 1 | Address falls inside the enabled window |
| sci | output | 1 | System control interrupt level |

## Verification
The bench places the window at a base whose low six bits are set, so a decoder that kept those bits would miss every access. It then probes an address one window above, where a loose decoder would respond.

It raises an event in the same cycle that software clears that bit; a design that gave the clear priority would lose the event. It writes zeros to status, where a design lacking write-one-to-clear would wipe pending events. It sets an enable bit outside the qualifying four, which an unmasked SCI would let through.

It runs the timer past its MSB change with timer enable off and then on. A design without the arming condition would set the timer status in the first run, and one watching the wrong bit would set it at the wrong count.

// File: rtl/pm_event_sci.sv
module pm_event_sci #(
  parameter int TMR_W    = 24,
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tmr_tick,
  input  logic        pwrbtn_evt,
  input  logic        rtc_evt,
  input  logic        glock_evt,
  input  logic [31:0] cfg_base,
  input  logic [7:0]  cfg_ctrl,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic [15:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_hit,
  output logic        sci
);
  localparam logic [ADDR_W-1:0] WIN_MASK = {ADDR_W{1'b1}} << WIN_LOG2;
  localparam logic [15:0] SRC_MASK = 16'h0521;
  localparam logic [WIN_LOG2-1:0] OFS_STS = WIN_LOG2'(0);
  localparam logic [WIN_LOG2-1:0] OFS_EN  = WIN_LOG2'(2);
  localparam logic [WIN_LOG2-1:0] OFS_TMR = WIN_LOG2'(8);

  logic [15:0]         sts_q, en_q, set_v, clr_v;
  logic [TMR_W-1:0]    cnt_q;
  logic [WIN_LOG2-1:0] ofs;
  logic                msb_flip;

  assign io_hit   = cfg_ctrl[0] && ((io_addr & WIN_MASK) == (cfg_base[ADDR_W-1:0] & WIN_MASK));
  assign ofs      = io_addr[WIN_LOG2-1:0];
  assign msb_flip = tmr_tick && (&cnt_q[TMR_W-2:0]);

  always_comb begin
    set_v = 16'h0;
    set_v[0]  = msb_flip && en_q[0];
    set_v[5]  = glock_evt;
    set_v[8]  = pwrbtn_evt;
    set_v[10] = rtc_evt;
    clr_v = (io_wr && io_hit && ofs == OFS_STS) ? io_wdata : 16'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      cnt_q <= '0;
    end else begin
      sts_q <= ((sts_q & ~clr_v) | set_v) & SRC_MASK;
      if (io_wr && io_hit && ofs == OFS_EN) en_q <= io_wdata;
      if (tmr_tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_hit) begin
      case (ofs)
        OFS_STS: io_rdata = {16'h0, sts_q};
        OFS_EN:  io_rdata = {16'h0, en_q};
        OFS_TMR: io_rdata = 32'(cnt_q);
        default: io_rdata = '0;
      endcase
    end
  end

  assign sci = |(sts_q & en_q & SRC_MASK);

  assert_sci_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> (sts_q != 16'h0 && en_q != 16'h0));
  assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrbtn_evt || rtc_evt || glock_evt) |=> (sts_q != 16'h0));
  assert_w1c_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sts_q) & ~sts_q)) |-> $past(io_wr && io_hit && ofs == OFS_STS));
  assert_tmr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_tmr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_tick |=> $stable(cnt_q));
  assert_tmr_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[0]) |-> $past(en_q[0] && tmr_tick));
  assert_closed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ctrl[0] |-> (io_rdata == 32'h0 && !io_hit));
endmodule

// File: tb/test_pm_event_sci.sv
module test_pm_event_sci;
  localparam int TW = 8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_tick = 1'b0, pwrbtn_evt = 1'b0, rtc_evt = 1'b0, glock_evt = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [7:0]  cfg_ctrl = '0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_hit, sci;

  int checks = 0, errors = 0;
  int m_sts = 0, m_en = 0, m_cnt = 0;

  always #2 clk = ~clk;

  pm_event_sci #(.TMR_W(TW)) i_pm_event_sci (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .pwrbtn_evt(pwrbtn_evt),
    .rtc_evt(rtc_evt), .glock_evt(glock_evt), .cfg_base(cfg_base), .cfg_ctrl(cfg_ctrl),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_hit(io_hit), .sci(sci));

  function automatic bit m_hit();
    return cfg_ctrl[0] && ((int'(io_addr) & 'hFFC0) == (int'(cfg_base[15:0]) & 'hFFC0));
  endfunction

  function automatic int m_rd();
    if (!m_hit()) return 0;
    case (int'(io_addr) & 63)
      0: return m_sts;
      2: return m_en;
      8: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    int set, clr;
    #1;
    chk(tag, "io_hit", int'(io_hit), int'(m_hit()));
    chk(tag, "io_rdata", int'(io_rdata), m_rd());
    chk("R9", "sci", int'(sci), int'((m_sts & m_en & 'h0521) != 0));
    set = (pwrbtn_evt ? 'h100 : 0) | (rtc_evt ? 'h400 : 0) | (glock_evt ? 'h20 : 0);
    if (tmr_tick && (((m_cnt + 1) >> (TW-1)) & 1) != ((m_cnt >> (TW-1)) & 1) && (m_en & 1))
      set |= 1;
    clr = (io_wr && m_hit() && (int'(io_addr) & 63) == 0) ? int'(io_wdata) : 0;
    @(posedge clk);
    if (io_wr && m_hit() && (int'(io_addr) & 63) == 2) m_en = int'(io_wdata);
    m_sts = ((m_sts & ~clr) | set) & 'h0521;
    if (tmr_tick) m_cnt = (m_cnt + 1) % (1 << TW);
    @(negedge clk);
  endtask

  task automatic acc(int a, bit w, int d, string tag);
    io_addr = 16'(a); io_wr = w; io_wdata = 16'(d);
    step(tag);
    io_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cfg_base = 32'h1234_5A7F; cfg_ctrl = 8'h01;
    acc('h5A40, 0, 0, "R1");
    acc('h5A42, 0, 0, "R1");
    acc('h5A48, 0, 0, "R1");
    cfg_ctrl = 8'h00;
    acc('h5A42, 1, 'hFFFF, "R3");
    cfg_ctrl = 8'h01;
    acc('h5A42, 0, 0, "R3");
    acc('h5A82, 1, 'h1234, "R2");
    acc('h5A42, 0, 0, "R2");
    acc('h5A42, 1, 'h0002, "R6");
    acc('h5A42, 0, 0, "R6");
    pwrbtn_evt = 1'b1; acc('h5A40, 0, 0, "R4"); pwrbtn_evt = 1'b0;
    acc('h5A40, 0, 0, "R9");
    acc('h5A42, 1, 'h0521, "R6");
    acc('h5A40, 0, 0, "R9");
    acc('h5A40, 1, 'h0000, "R5");
    acc('h5A40, 1, 'h0100, "R5");
    acc('h5A40, 0, 0, "R5");
    rtc_evt = 1'b1; glock_evt = 1'b1;
    acc('h5A40, 1, 'h0420, "R4");
    rtc_evt = 1'b0; glock_evt = 1'b0;
    acc('h5A40, 0, 0, "R4");
    acc('h5A40, 1, 'hFFFF, "R5");
    acc('h5A44, 1, 'hFFFF, "R10");
    acc('h5A44, 0, 0, "R10");
    acc('h5A7E, 0, 0, "R10");
    acc('h5A42, 1, 'h0000, "R8");
    tmr_tick = 1'b1;
    for (int i = 0; i < 300; i++) acc('h5A48, 0, 0, "R8");
    acc('h5A48, 1, 'h0055, "R7");
    acc('h5A42, 1, 'h0001, "R8");
    for (int i = 0; i < 300; i++) acc((i % 2) ? 'h5A40 : 'h5A48, 0, 0, "R7");
    tmr_tick = 1'b0;
    acc('h5A48, 0, 0, "R7");
    acc('h5A40, 0, 0, "R8");
    rst_n = 1'b0; m_sts = 0; m_en = 0; m_cnt = 0;
    #1;
    chk("R1", "sci", int'(sci), 0);
    chk("R1", "io_rdata", int'(io_rdata), 0);
    @(negedge clk); rst_n = 1'b1;
    acc('h5A42, 0, 0, "R1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule